// File: doc/BRIEF.md
# Bit-field extract and place unit

This unit handles contiguous bit fields on an XLEN-wide datapath (64 bits by default). It has three operations. Unsigned extract and signed extract pull a field of up to 16 bits out of operand A, starting at a 5-bit offset, and return it right-justified. The bits above the field are filled with zeros for the unsigned form and with copies of the field's top bit for the signed form. Place takes the low bits of operand A and writes them into operand B at a chosen offset and length. Every other bit of B comes through unchanged.

The length and offset arrive as compact codes. A length code of 0 means a 16-bit field. For place only, an offset code of 0 means offset 32. The operation code, the two field codes and both operands are sampled on every rising clock edge, and the result appears in a register one cycle later. The unit never reads past the top of the word: extract sees zeros above bit XLEN-1, and place drops any inserted bits that would land above it.

Top module: `bfu_unit`

## Requirements
- R1: While rstN is low the result is 0, and the result clears to 0 at once when rstN falls.
- R2: The result updates only at a rising clock edge, from the inputs sampled at that edge. Between edges it holds its value.
- R3: A length code from 1 to 15 selects that many bits, and length code 0 selects 16 bits.
- R4: With opCode 2'b00 (unsigned extract), the result is bits [off+len-1:off] of srcA, right-justified, with every higher bit 0.
- R5: With opCode 2'b10 (signed extract), the same field is returned sign-extended from its top bit, bit len-1.
- R6: An extract with offset code 0 returns the low len bits of srcA, sign- or zero-extended.
- R7: With opCode 2'b01 (place), result bits [off+len-1:off] equal srcA[len-1:0], and all other bits equal srcB.
- R8: For place, offset code 0 means offset 32, and offset codes 1 to 31 are taken as written.
- R9: Extract reads zeros above bit XLEN-1 before extending, and place discards inserted bits above bit XLEN-1. This is shown with XLEN = 32.
- R10: opCode 2'b11 is reserved and gives a result of 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 2 | 00 unsigned extract, 01 place, 10 signed extract, 11 reserved |
| offCode | input | 5 | Field offset code |
| lenCode | input | 4 | Field length code (0 means 16) |
| srcA | input | XLEN | Source word for extract, or the bits to insert for place |
| srcB | input | XLEN | Background word for place |
| result | output | XLEN | Registered result |

## Verification
The unit's only internal state is the decoded strobe set and the result register. A wrong decode therefore shows up at the result port on the cycle right after the bad inputs are sampled. Decode errors have recognisable signatures:
- A length code of 0 taken literally leaves an all-zero field, or a sign fill in the wrong place.
- A place offset code of 0 taken literally overwrites the low bits of srcB.
- A swapped sign strobe shows up as ones or zeros above bit 15.
- A stale register appears as the previous vector's value.
Vectors where the field's top bit is 1, and fields that sit against bit 31, make each of these errors show at the port.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int LenFieldW = 4;
  localparam int OffFieldW = 5;
  localparam int MaxLen    = 1 << LenFieldW;
  localparam int MaxOff    = 1 << OffFieldW;
  localparam int LenW      = $clog2(MaxLen + 1);
  localparam int OffW      = $clog2(MaxOff + 1);

  typedef enum logic [1:0] {
    OP_ZEXT  = 2'b00,
    OP_PLACE = 2'b01,
    OP_SEXT  = 2'b10,
    OP_RSVD  = 2'b11
  } bfuOp_e;

  typedef struct packed {
    logic            extract;
    logic            signExt;
    logic            place;
    logic [OffW-1:0] shamt;
    logic [LenW-1:0] width;
  } bfuStrobe_t;
endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic [1:0]           opCode,
  input  logic [OffFieldW-1:0] offCode,
  input  logic [LenFieldW-1:0] lenCode,
  output bfuStrobe_t           stb
);
  bfuOp_e op;
  logic   offIsZero;
  logic   lenIsZero;

  always_comb begin
    op        = bfuOp_e'(opCode);
    offIsZero = (offCode == '0);
    lenIsZero = (lenCode == '0);

    stb.extract = (op == OP_ZEXT) || (op == OP_SEXT);
    stb.signExt = (op == OP_SEXT);
    stb.place   = (op == OP_PLACE);

    // A zero length code means the widest field.
    stb.width = lenIsZero ? LenW'(MaxLen) : LenW'(lenCode);

    // Only place gives a zero offset code its far meaning.
    if (stb.place && offIsZero) stb.shamt = OffW'(MaxOff);
    else                        stb.shamt = OffW'(offCode);
  end
endmodule

// File: rtl/bfu_dpath.sv
module bfu_dpath
  import bfu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  bfuStrobe_t       stb,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [XLEN-1:0]  nextVal
);
  logic [XLEN-1:0] fieldMask;
  logic [XLEN-1:0] shiftedA;
  logic [XLEN-1:0] rawField;
  logic            signBit;
  logic [XLEN-1:0] extOut;
  logic [XLEN-1:0] placeMask;
  logic [XLEN-1:0] placeData;
  logic [XLEN-1:0] placeOut;

  always_comb begin
    // Ones in the low `width` bits.
    fieldMask = ~({XLEN{1'b1}} << stb.width);

    // Extract path: shifting brings zeros in from above the top bit.
    shiftedA = srcA >> stb.shamt;
    rawField = shiftedA & fieldMask;
    signBit  = |(rawField & ~(fieldMask >> 1));
    extOut   = (stb.signExt && signBit) ? (rawField | ~fieldMask) : rawField;

    // Place path: bits shifted past the top simply fall off.
    placeMask = fieldMask << stb.shamt;
    placeData = (srcA << stb.shamt) & placeMask;
    placeOut  = (srcB & ~placeMask) | placeData;

    if (stb.extract)    nextVal = extOut;
    else if (stb.place) nextVal = placeOut;
    else                nextVal = '0;
  end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
  import bfu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           opCode,
  input  logic [OffFieldW-1:0] offCode,
  input  logic [LenFieldW-1:0] lenCode,
  input  logic [XLEN-1:0]      srcA,
  input  logic [XLEN-1:0]      srcB,
  output logic [XLEN-1:0]      result
);
  bfuStrobe_t      stb;
  logic [XLEN-1:0] nextVal;

  bfu_ctrl ctrlI (
    .opCode  (opCode),
    .offCode (offCode),
    .lenCode (lenCode),
    .stb     (stb)
  );

  bfu_dpath #(.XLEN(XLEN)) dpathI (
    .stb     (stb),
    .srcA    (srcA),
    .srcB    (srcB),
    .nextVal (nextVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= nextVal;
  end
endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk
  import bfu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           opCode,
  input logic [OffFieldW-1:0] offCode,
  input logic [LenFieldW-1:0] lenCode,
  input logic [XLEN-1:0]      srcA,
  input logic [XLEN-1:0]      srcB,
  input logic [XLEN-1:0]      result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (result == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $stable(opCode) && $stable(offCode) && $stable(lenCode)
      && $stable(srcA) && $stable(srcB)) |=> $stable(result));

  // R4
  zext_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 2'b00) |-> (result[XLEN-1:MaxLen] == '0));

  // R5
  sext_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 2'b10) |->
      ((&result[XLEN-1:MaxLen-1]) || !(|result[XLEN-1:MaxLen-1])));

  // R8
  place_far_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 2'b01 && $past(offCode) == '0) |->
      (result[MaxOff-1:0] == $past(srcB[MaxOff-1:0])));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 2'b11) |-> (result == '0));
endmodule

bind bfu_unit bfu_unit_chk #(.XLEN(XLEN)) chkI (.*);

// File: tb/tb_bfu_unit.sv
`timescale 1ns/1ps
module tb_bfu_unit;
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  off;
    logic [3:0]  len;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 5'd0,  4'd8, PAT, 64'h0, 64'h0000_0000_0000_00EF},
    '{2'b10, 5'd0,  4'd8, PAT, 64'h0, 64'hFFFF_FFFF_FFFF_FFEF},
    '{2'b00, 5'd4,  4'd0, PAT, 64'h0, 64'h0000_0000_0000_BCDE},
    '{2'b10, 5'd4,  4'd0, PAT, 64'h0, 64'hFFFF_FFFF_FFFF_BCDE},
    '{2'b10, 5'd31, 4'd5, PAT, 64'h0, 64'h0000_0000_0000_000F},
    '{2'b00, 5'd8,  4'd3, PAT, 64'h0, 64'h0000_0000_0000_0005},
    '{2'b00, 5'd31, 4'd0, PAT, 64'h0, 64'h0000_0000_0000_8ACF},
    '{2'b10, 5'd31, 4'd0, PAT, 64'h0, 64'hFFFF_FFFF_FFFF_8ACF},
    '{2'b10, 5'd2,  4'd1, 64'h4, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'b01, 5'd8,  4'd8, 64'hAA, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_AA44},
    '{2'b01, 5'd0,  4'd0, 64'hFFFF_BEEF, 64'h0, 64'h0000_BEEF_0000_0000},
    '{2'b01, 5'd1,  4'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD},
    '{2'b11, 5'd3,  4'd4, PAT, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
  };
  localparam string TAGS [NV] = '{
    "R4 R6 zext off0", "R5 R6 sext off0", "R3 R4 zext len16", "R3 R5 sext len16",
    "R5 sext top clear", "R4 zext mid", "R4 R3 zext at bit31", "R5 R3 sext at bit31",
    "R5 single bit", "R7 place", "R8 R3 place off32", "R7 place clear bit", "R10 reserved"
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opCode = '0;
  logic [4:0]  offCode = '0;
  logic [3:0]  lenCode = '0;
  logic [63:0] srcA = '0, srcB = '0;
  logic [63:0] result;
  logic [1:0]  op32 = '0;
  logic [4:0]  off32 = '0;
  logic [3:0]  len32 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [31:0] res32;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bfu_unit #(.XLEN(64)) dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .offCode(offCode), .lenCode(lenCode),
    .srcA(srcA), .srcB(srcB), .result(result));

  bfu_unit #(.XLEN(32)) dut32 (
    .clk(clk), .rstN(rstN), .opCode(op32), .offCode(off32), .lenCode(len32),
    .srcA(a32), .srcB(b32), .result(res32));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive32(input logic [1:0] o, input logic [4:0] f, input logic [3:0] l,
                         input logic [31:0] a, input logic [31:0] b);
    op32 = o; off32 = f; len32 = l; a32 = a; b32 = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 reset result", result, 64'h0);
    chk("R1 reset result32", {32'h0, res32}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opCode = VECS[i].op; offCode = VECS[i].off; lenCode = VECS[i].len;
      srcA = VECS[i].a; srcB = VECS[i].b;
      @(negedge clk);
      chk(TAGS[i], result, VECS[i].exp);
    end

    // R2: a new input does not show before the next rising edge
    @(negedge clk);
    opCode = 2'b00; offCode = 5'd0; lenCode = 4'd4; srcA = 64'hF5;
    #1 chk("R2 hold until edge", result, 64'h0);
    @(negedge clk);
    chk("R2 update after edge", result, 64'h5);

    // R9: XLEN=32 top-of-word behaviour
    drive32(2'b00, 5'd31, 4'd0, 32'hFFFF_FFFF, 32'h0);
    @(negedge clk);
    chk("R9 zext past top", {32'h0, res32}, 64'h1);
    drive32(2'b10, 5'd31, 4'd0, 32'hFFFF_FFFF, 32'h0);
    @(negedge clk);
    chk("R9 sext past top", {32'h0, res32}, 64'h1);
    drive32(2'b01, 5'd20, 4'd0, 32'h0000_FABC, 32'h0000_1234);
    @(negedge clk);
    chk("R9 place drops high", {32'h0, res32}, 64'hABC0_1234);
    drive32(2'b01, 5'd0, 4'd0, 32'hFFFF_FFFF, 32'h0000_1234);
    @(negedge clk);
    chk("R9 R8 place off32 narrow", {32'h0, res32}, 64'h1234);

    // R1: asynchronous clear mid-run
    srcA = 64'hFF; lenCode = 4'd8;
    @(negedge clk);
    chk("R1 pre-reset value", result, 64'hFF);
    rstN = 1'b0;
    #1 chk("R1 async clear", result, 64'h0);
    @(negedge clk);
    chk("R1 stays clear", result, 64'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule